// File: doc/BRIEF.md
# Memory Region Permission Checker

This block decides, for each memory access a processor issues, whether the access may proceed. It holds no configuration of its own. Up to sixteen regions are presented on its configuration ports, each with a base address, a power-of-two size code, an eight-way subregion mask, a permission code, an execute-never bit and an enable bit. Three control bits sit beside them: a global enable, a privileged background-map enable and a handler-check enable.

Each cycle, a request carries an address, a write flag, an instruction-fetch flag, a privilege flag and an exception-handler flag. All regions are compared in parallel. The highest-numbered matching region wins, and its permission and execute-never rules decide the outcome. One cycle later the result appears with a valid strobe, a fault flag, a hit flag and the index of the winning region. A core's load/store and fetch units use the fault flag to abort the access.

Top module: `mem_guard`

## Requirements
- R1: A region with size code S (5 bits) covers 2^(S+1) bytes. Codes 0 to 3 are reserved, and a region carrying one never matches. Code 31 covers the full 4 GB space.
- R2: Only the base bits above the region size, that is address bits [31:S+1], are compared with the request address. The base is supplied as address bits [31:5].
- R3: When S >= 7, bit k of the eight-bit subregion mask disables the eighth of the region whose index is address bits [S:S-2]. A disabled eighth does not match. When S < 7 the mask is ignored.
- R4: A region whose enable bit is 0 never matches.
- R5: When several regions match, the highest index wins. A region that is excluded by its subregion mask lets a lower region, or the miss rule, apply.
- R6: Permission codes: 0 faults on every access. 1 allows privileged read and write and faults on every unprivileged access. 2 allows privileged read and write and unprivileged read. 3 never faults.
- R7: Permission code 5 allows only privileged reads. Code 6 allows reads at both levels and faults on every write. Codes 4 and 7 fault on every access.
- R8: An instruction fetch that hits a region with execute-never set faults. Otherwise a fetch is judged as a read.
- R9: An access that hits no region is allowed when it is privileged and the background enable is 1; otherwise it faults. A miss reports hit 0 and index 0.
- R10: When the handler-check enable is 0, an access with the handler flag set passes with hit 0. When it is 1, such an access is checked normally.
- R11: When the global enable is 0, every access passes with no fault and hit 0.
- R12: The result is registered. rsp_valid follows req_valid one cycle later. Fault, hit and index are 0 in a cycle with no valid result. Reset is synchronous and active low, and it clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| guard_en | input | 1 | Global checker enable |
| bg_en | input | 1 | Privileged background map enable |
| hdl_chk_en | input | 1 | Check accesses made by exception handlers |
| cfg_base | input | NREG*27 | Region base address bits [31:5], region i at [i*27 +: 27] |
| cfg_size | input | NREG*5 | Region size codes |
| cfg_sub_off | input | NREG*8 | Subregion disable masks |
| cfg_perm | input | NREG*3 | Permission codes |
| cfg_xn | input | NREG | Execute-never bits |
| cfg_en | input | NREG | Region enable bits |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_priv | input | 1 | 1 = privileged access |
| req_handler | input | 1 | 1 = access made by an exception handler |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Access denied |
| rsp_hit | output | 1 | A region decided the result |
| rsp_region | output | IDXW | Index of the winning region |

## Verification
The clocked properties assume that the configuration and control inputs are stable from the cycle of a request until its result, because the comparison is made in the request cycle. The bench changes region settings and control bits only between accesses, while req_valid is low. The immediate properties on the priority selector assume that every match line is a known value. The bench gives every region a defined configuration out of reset, and disabled regions still carry defined fields.

// File: rtl/mg_pkg.sv
// Shared constants and the permission code type for the region checker.
// Assumes a 32-bit address space and a 32-byte minimum region granule.
package mg_pkg;
    localparam int ADDR_W   = 32;
    localparam int BASE_LSB = 5;
    localparam int BASE_W   = ADDR_W - BASE_LSB;
    localparam int SIZE_W   = 5;
    localparam int SUB_W    = 8;
    localparam int PERM_W   = 3;
    localparam logic [SIZE_W-1:0] SIZE_MIN     = 5'd4;
    localparam logic [SIZE_W-1:0] SIZE_SUB_MIN = 5'd7;

    typedef enum logic [PERM_W-1:0] {
        PERM_NONE      = 3'd0,
        PERM_PRIV_RW   = 3'd1,
        PERM_USER_RO   = 3'd2,
        PERM_FULL      = 3'd3,
        PERM_RSV_A     = 3'd4,
        PERM_PRIV_RO   = 3'd5,
        PERM_ALL_RO    = 3'd6,
        PERM_RSV_B     = 3'd7
    } perm_e;
endpackage

// File: rtl/mg_region_match.sv
// Decides whether one region claims an address.
// Checks the enable bit, the reserved size codes, the aligned base and the subregion mask.
// Assumes the base is aligned to the region size; bits below the size are not compared.
module mg_region_match
    import mg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    input  logic [SIZE_W-1:0] size,
    input  logic [SUB_W-1:0]  sub_off,
    input  logic              en,
    output logic              match
);
    logic              above_ok;
    logic [SIZE_W-1:0] sub_sh;
    logic [2:0]        sub_idx;
    logic              sub_blocked;

    // Compare the base bits that lie above the region size (R2)
    always_comb begin
        above_ok = 1'b1;
        for (int b = BASE_LSB; b < ADDR_W; b++) begin
            if (b > int'(size) && addr[b] != base[b-BASE_LSB])
                above_ok = 1'b0;
        end
    end

    // Pick the eighth of the region and look up its disable bit (R3)
    always_comb begin
        sub_sh      = (size >= SIZE_SUB_MIN) ? size - 5'd2 : '0;
        sub_idx     = addr[sub_sh +: 3];
        sub_blocked = (size >= SIZE_SUB_MIN) && sub_off[sub_idx];
    end

    // Final claim: enabled, legal size, base equal, eighth not disabled (R1, R4)
    always_comb begin
        match = en && (size >= SIZE_MIN) && above_ok && !sub_blocked;
    end
endmodule

// File: rtl/mg_prio_sel.sv
// Reduces the per-region match lines to one winner, with the highest index taking priority.
// Assumes the match lines are known values in every cycle.
module mg_prio_sel #(
    parameter int NREG = 16,
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [NREG-1:0] match,
    output logic            hit,
    output logic [IDXW-1:0] idx
);
    // Scan upward so that the last matching region found is kept (R5)
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDXW'(i);
            end
        end
    end

    // Check that the winner really matched and no higher region matched (R5)
    always_comb begin
        if (hit) begin
            a_r5_winner_matched: assert (match[idx]);
        end
        for (int j = 0; j < NREG; j++) begin
            if (hit && j > int'(idx)) begin
                a_r5_highest_wins: assert (!match[j]);
            end
        end
        if (!hit) begin
            a_r5_no_hit_no_match: assert (match == '0);
        end
    end
endmodule

// File: rtl/mg_perm_eval.sv
// Applies a region's permission code and execute-never bit to one access.
// Assumes a fetch is a read; reserved codes 4 and 7 deny everything.
module mg_perm_eval
    import mg_pkg::*;
(
    input  logic [PERM_W-1:0] perm,
    input  logic              xn,
    input  logic              write,
    input  logic              fetch,
    input  logic              priv,
    output logic              deny
);
    logic wr;
    logic code_deny;

    // Decode the permission table for this privilege level and direction (R6, R7)
    always_comb begin
        wr = write && !fetch;
        unique case (perm_e'(perm))
            PERM_NONE:    code_deny = 1'b1;
            PERM_PRIV_RW: code_deny = !priv;
            PERM_USER_RO: code_deny = !priv && wr;
            PERM_FULL:    code_deny = 1'b0;
            PERM_PRIV_RO: code_deny = !priv || wr;
            PERM_ALL_RO:  code_deny = wr;
            default:      code_deny = 1'b1;
        endcase
    end

    // Execute-never overrides the code for fetches (R8)
    always_comb begin
        deny = code_deny || (fetch && xn);
    end
endmodule

// File: rtl/mem_guard.sv
// Checks each access against all configured regions and registers a permit or fault result.
// Assumes the configuration and control inputs are stable while a request is being judged.
module mem_guard
    import mg_pkg::*;
#(
    parameter int NREG = 16,
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   guard_en,
    input  logic                   bg_en,
    input  logic                   hdl_chk_en,
    input  logic [NREG*BASE_W-1:0] cfg_base,
    input  logic [NREG*SIZE_W-1:0] cfg_size,
    input  logic [NREG*SUB_W-1:0]  cfg_sub_off,
    input  logic [NREG*PERM_W-1:0] cfg_perm,
    input  logic [NREG-1:0]        cfg_xn,
    input  logic [NREG-1:0]        cfg_en,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   req_write,
    input  logic                   req_fetch,
    input  logic                   req_priv,
    input  logic                   req_handler,
    output logic                   rsp_valid,
    output logic                   rsp_fault,
    output logic                   rsp_hit,
    output logic [IDXW-1:0]        rsp_region
);
    logic [NREG-1:0]   match;
    logic              sel_hit;
    logic [IDXW-1:0]   sel_idx;
    logic [PERM_W-1:0] sel_perm;
    logic              sel_xn;
    logic              region_deny;
    logic              bypass;
    logic              fault_d;

    // One comparator per region
    for (genvar g = 0; g < NREG; g++) begin : g_region
        mg_region_match u_match (
            .addr    (req_addr),
            .base    (cfg_base[g*BASE_W +: BASE_W]),
            .size    (cfg_size[g*SIZE_W +: SIZE_W]),
            .sub_off (cfg_sub_off[g*SUB_W +: SUB_W]),
            .en      (cfg_en[g]),
            .match   (match[g])
        );
    end

    mg_prio_sel #(.NREG(NREG)) u_sel (
        .match (match),
        .hit   (sel_hit),
        .idx   (sel_idx)
    );

    // Fetch the winning region's rule fields
    always_comb begin
        sel_perm = cfg_perm[int'(sel_idx)*PERM_W +: PERM_W];
        sel_xn   = cfg_xn[sel_idx];
    end

    mg_perm_eval u_perm (
        .perm  (sel_perm),
        .xn    (sel_xn),
        .write (req_write),
        .fetch (req_fetch),
        .priv  (req_priv),
        .deny  (region_deny)
    );

    // Combine bypass, region verdict and the miss rule (R9, R10, R11)
    always_comb begin
        bypass  = !guard_en || (req_handler && !hdl_chk_en);
        fault_d = !bypass && (sel_hit ? region_deny : !(req_priv && bg_en));
    end

    // Register the result one cycle after the request (R12)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_region <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_fault  <= req_valid && fault_d;
            rsp_hit    <= req_valid && !bypass && sel_hit;
            rsp_region <= (req_valid && !bypass && sel_hit) ? sel_idx : '0;
        end
    end

    a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault && !rsp_hit));
    a_r11_off_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !guard_en) |=> (!rsp_fault && !rsp_hit));
    a_r10_handler_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_handler && !hdl_chk_en) |=> !rsp_fault);
    a_r9_background_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && guard_en && bg_en && req_priv && !sel_hit) |=> !rsp_fault);
    a_r9_user_miss_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && guard_en && !sel_hit && !req_priv && !(req_handler && !hdl_chk_en))
        |=> (rsp_fault && !rsp_hit));
endmodule

// File: tb/test_mem_guard.sv
// Directed bench for mem_guard: one task per scenario, each checking its own results.
module test_mem_guard;
    localparam int NREG = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic guard_en = 1'b0, bg_en = 1'b0, hdl_chk_en = 1'b1;
    logic [NREG*27-1:0] cfg_base;
    logic [NREG*5-1:0]  cfg_size;
    logic [NREG*8-1:0]  cfg_sub_off;
    logic [NREG*3-1:0]  cfg_perm;
    logic [NREG-1:0]    cfg_xn, cfg_en;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0, req_fetch = 1'b0, req_priv = 1'b0, req_handler = 1'b0;
    logic        rsp_valid, rsp_fault, rsp_hit;
    logic [3:0]  rsp_region;

    logic [31:0] r_base [NREG];
    logic [4:0]  r_size [NREG];
    logic [7:0]  r_sub  [NREG];
    logic [2:0]  r_perm [NREG];
    logic        r_xn   [NREG];
    logic        r_en   [NREG];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            cfg_base[i*27 +: 27]  = r_base[i][31:5];
            cfg_size[i*5 +: 5]    = r_size[i];
            cfg_sub_off[i*8 +: 8] = r_sub[i];
            cfg_perm[i*3 +: 3]    = r_perm[i];
            cfg_xn[i]             = r_xn[i];
            cfg_en[i]             = r_en[i];
        end
    end

    mem_guard #(.NREG(NREG)) i_mem_guard (
        .clk(clk), .rst_n(rst_n), .guard_en(guard_en), .bg_en(bg_en), .hdl_chk_en(hdl_chk_en),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_sub_off(cfg_sub_off),
        .cfg_perm(cfg_perm), .cfg_xn(cfg_xn), .cfg_en(cfg_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_fetch(req_fetch), .req_priv(req_priv), .req_handler(req_handler),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_hit(rsp_hit), .rsp_region(rsp_region)
    );

    // Program one region (changed only while no request is in flight)
    task automatic set_region(input int i, input logic [31:0] b, input logic [4:0] s,
                              input logic [7:0] sub, input logic [2:0] p, input bit x, input bit e);
        r_base[i] = b; r_size[i] = s; r_sub[i] = sub; r_perm[i] = p; r_xn[i] = x; r_en[i] = e;
    endtask

    // Issue one access and compare the registered result one cycle later
    task automatic access(input logic [31:0] a, input bit wr, input bit fe, input bit pv,
                          input bit hd, input bit ef, input bit eh, input int ei, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_fetch = fe;
        req_priv = pv; req_handler = hd;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_fault !== ef || rsp_hit !== eh || rsp_region !== 4'(ei)) begin
            errors++;
            $display("FAIL %s addr=%h: got valid=%b fault=%b hit=%b region=%0d, expected valid=1 fault=%b hit=%b region=%0d",
                     tag, a, rsp_valid, rsp_fault, rsp_hit, rsp_region, ef, eh, ei);
        end
    endtask

    task automatic test_reset();
        // R12: outputs held at zero during reset even with a request present
        req_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_hit !== 1'b0 || rsp_region !== 4'd0) begin
            errors++;
            $display("FAIL R12 reset: got valid=%b fault=%b hit=%b region=%0d, expected all 0",
                     rsp_valid, rsp_fault, rsp_hit, rsp_region);
        end
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R12 idle: got valid=%b expected 0", rsp_valid);
        end
    endtask

    task automatic test_size_base();
        set_region(0, 32'h2000_0000, 5'd9, 8'h00, 3'd3, 1'b0, 1'b1);   // 1 KB, full access
        set_region(1, 32'h3000_0000, 5'd2, 8'h00, 3'd3, 1'b0, 1'b1);   // reserved size code
        access(32'h2000_0000, 0, 0, 0, 0, 0, 1, 0, "R1 lowest byte");
        access(32'h2000_03FC, 0, 0, 0, 0, 0, 1, 0, "R1 top word");
        access(32'h2000_0400, 0, 0, 0, 0, 1, 0, 0, "R1 one past end");
        access(32'h2100_0000, 0, 0, 0, 0, 1, 0, 0, "R2 upper base bit differs");
        access(32'h3000_0000, 0, 0, 0, 0, 1, 0, 0, "R1 reserved code never matches");
    endtask

    task automatic test_disabled();
        set_region(2, 32'h4000_0000, 5'd11, 8'h00, 3'd3, 1'b0, 1'b0);
        access(32'h4000_0010, 0, 0, 0, 0, 1, 0, 0, "R4 disabled region");
    endtask

    task automatic test_subregions();
        set_region(3, 32'h5000_0000, 5'd9, 8'h04, 3'd3, 1'b0, 1'b1);   // eighth 2 off
        set_region(4, 32'h6000_0000, 5'd6, 8'hFF, 3'd3, 1'b0, 1'b1);   // 128 B, mask ignored
        access(32'h5000_0100, 0, 0, 0, 0, 1, 0, 0, "R3 disabled eighth");
        access(32'h5000_0080, 0, 0, 0, 0, 0, 1, 3, "R3 enabled eighth");
        access(32'h6000_0000, 0, 0, 0, 0, 0, 1, 4, "R3 mask ignored below 256 B");
    endtask

    task automatic test_priority();
        set_region(5, 32'h7000_0000, 5'd19, 8'h00, 3'd3, 1'b0, 1'b1);  // 1 MB full
        set_region(6, 32'h7000_0000, 5'd11, 8'h00, 3'd0, 1'b0, 1'b1);  // 4 KB none
        access(32'h7000_0010, 0, 0, 1, 0, 1, 1, 6, "R5 higher index wins");
        access(32'h7000_2000, 0, 0, 1, 0, 0, 1, 5, "R5 lower region outside overlap");
        r_sub[6] = 8'h01;
        access(32'h7000_0010, 0, 0, 1, 0, 0, 1, 5, "R5 fall through disabled eighth");
    endtask

    // Expected fault per code from R6/R7 for a data access
    function automatic bit perm_fault(input int code, input bit wr, input bit pv);
        case (code)
            0: return 1'b1;
            1: return !pv;
            2: return !pv && wr;
            3: return 1'b0;
            5: return !pv || wr;
            6: return wr;
            default: return 1'b1;
        endcase
    endfunction

    task automatic test_perms();
        for (int code = 0; code < 8; code++) begin
            r_perm[0] = 3'(code);
            for (int k = 0; k < 4; k++) begin
                bit wr = k[0];
                bit pv = k[1];
                access(32'h2000_0010, wr, 0, pv, 0, perm_fault(code, wr, pv), 1, 0,
                       (code == 5 || code == 6 || code == 4 || code == 7) ? "R7 permission code" : "R6 permission code");
            end
        end
    endtask

    task automatic test_xn();
        set_region(0, 32'h2000_0000, 5'd9, 8'h00, 3'd3, 1'b1, 1'b1);
        access(32'h2000_0020, 0, 1, 0, 0, 1, 1, 0, "R8 fetch from execute-never");
        access(32'h2000_0020, 0, 0, 0, 0, 0, 1, 0, "R8 data read from execute-never");
        set_region(0, 32'h2000_0000, 5'd9, 8'h00, 3'd6, 1'b0, 1'b1);
        access(32'h2000_0020, 1, 1, 0, 0, 0, 1, 0, "R8 fetch judged as read");
        r_perm[0] = 3'd5;
        access(32'h2000_0020, 0, 1, 1, 0, 0, 1, 0, "R8 privileged fetch on code 5");
        access(32'h2000_0020, 0, 1, 0, 0, 1, 1, 0, "R8 user fetch on code 5");
    endtask

    task automatic test_background();
        bg_en = 1'b1;
        access(32'h9000_0000, 1, 0, 1, 0, 0, 0, 0, "R9 privileged miss via background");
        access(32'h9000_0000, 0, 0, 0, 0, 1, 0, 0, "R9 user miss with background");
        bg_en = 1'b0;
        access(32'h9000_0000, 0, 0, 1, 0, 1, 0, 0, "R9 privileged miss without background");
    endtask

    task automatic test_handler();
        r_perm[0] = 3'd0;
        hdl_chk_en = 1'b0;
        access(32'h2000_0040, 1, 0, 0, 1, 0, 0, 0, "R10 handler bypass");
        access(32'h2000_0040, 1, 0, 0, 0, 1, 1, 0, "R10 non-handler still checked");
        hdl_chk_en = 1'b1;
        access(32'h2000_0040, 1, 0, 0, 1, 1, 1, 0, "R10 handler checked");
    endtask

    task automatic test_global_off();
        guard_en = 1'b0;
        access(32'h2000_0040, 1, 1, 0, 0, 0, 0, 0, "R11 global disable");
        access(32'h9000_0000, 0, 0, 0, 0, 0, 0, 0, "R11 global disable miss");
        guard_en = 1'b1;
    endtask

    task automatic test_full_space();
        set_region(15, 32'h0000_0000, 5'd31, 8'h80, 3'd1, 1'b0, 1'b1); // 4 GB, top eighth off
        access(32'h1234_5678, 1, 0, 1, 0, 0, 1, 15, "R1 4 GB privileged write");
        access(32'h2000_0010, 0, 0, 0, 0, 1, 1, 15, "R5 4 GB region outranks region 0");
        access(32'hF000_0000, 0, 0, 1, 0, 1, 0, 0, "R3 top eighth of 4 GB disabled");
        access(32'hDFFF_FFF0, 0, 0, 0, 0, 1, 1, 15, "R6 code 1 user fault below top eighth");
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) set_region(i, 32'h0, 5'd4, 8'h00, 3'd0, 1'b0, 1'b0);
        test_reset();
        guard_en = 1'b1;
        test_size_base();
        test_disabled();
        test_subregions();
        test_priority();
        test_perms();
        test_xn();
        test_background();
        test_handler();
        test_global_off();
        test_full_space();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule